// File: doc/BRIEF.md
# Broadcast-Sample Rotating-Weight Convolver

This block computes a one-dimensional convolution of a sample stream with a small set of `K` weights. Every accepted sample goes to all `K` cells in the same cycle. The weights move around a ring of registers, one cell per accepted sample. Each cell multiplies the weight it currently holds by the common sample and adds the product into its own wide accumulator.

One weight in the ring carries a marker bit: the last weight of the set. The cell that holds the marked weight while a sample arrives finishes its sum with that sample. It places the sum on a shared result register and clears its accumulator, so it begins its next output from zero. Because the marker moves with the ring, completed results leave the cells in turn, one for each accepted sample.

Loading a new weight set places the weights around the ring, clears every accumulator and restarts the stream. Outputs count from the load. Samples before the first one accepted after the load are taken as zero.

Top module: `bcast_conv`

## Requirements
- R1: While reset is applied and in the first cycle after it, `y_valid` is 0 and `y_data` is 0.
- R2: Each accepted sample produces exactly one `y_valid` pulse in the next cycle. A sample is accepted when `x_valid` is 1 and `w_load` is 0. Cycles without an accepted sample produce no pulse.
- R3: Let the s-th accepted sample since the last load be x[s], counting from 0. The result emitted for it is the sum over j = 0..K-1 of w[j]·x[s-K+1+j], with x[n] = 0 for n < 0. The weight w[j] is the signed DW-bit field of `w_flat` at bits [j·DW +: DW]. All values are two's-complement, and `y_data` is the signed sum.
- R4: After a load, the first K-1 results are the partial sums over the samples received so far. An impulse of value 1 followed by zeros returns w[K-1], w[K-2], …, w[0], and then 0.
- R5: Cycles with `x_valid` low do not advance the computation. A stream with idle gaps gives the same results as the same stream sent without gaps.
- R6: A cycle with `w_load` high installs the new weights and discards all partial sums. It also ignores any sample presented in that cycle and gives no `y_valid` in the next cycle. The results that follow obey R3 with the sample count restarted.
- R7: `y_data` is 2·DW+clog2(K+1) bits wide. With the default parameters, full-scale inputs (all samples and weights at −2^(DW−1)) give the exact sum K·2^(2·DW−2) without overflow.
- R8: `y_data` keeps its last value in every cycle in which `y_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| w_load | input | 1 | Install the weight set on `w_flat` and restart |
| w_flat | input | K·DW | Packed signed weights, w[j] at bits [j·DW +: DW] |
| x_valid | input | 1 | Sample strobe |
| x_data | input | DW | Signed sample, sent to every cell |
| y_valid | output | 1 | Result strobe, one cycle after an accepted sample |
| y_data | output | 2·DW+clog2(K+1) | Signed convolution result |

## Verification
The hardest behaviour to reach from the ports is an accumulator that holds a partial sum when the ring's rotation is disturbed. This happens when idle cycles fall between samples that one result needs, or when a reload arrives while every cell holds an unfinished sum. The stimulus runs a long random stream with randomly placed idle gaps. Partway through, it reloads the weights with a sample presented in the same cycle. A software model of the sample history then checks each result against the zero-extended convolution.

// File: rtl/bcast_conv.sv
module bcast_conv #(
  parameter int K  = 3,
  parameter int DW = 8,
  localparam int AW = 2*DW + $clog2(K+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_load,
  input  logic [K*DW-1:0]   w_flat,
  input  logic              x_valid,
  input  logic [DW-1:0]     x_data,
  output logic              y_valid,
  output logic [AW-1:0]     y_data
);

  logic signed [DW-1:0]   wr   [K];
  logic        [K-1:0]    tg;
  logic signed [AW-1:0]   acc  [K];
  logic signed [2*DW-1:0] prod [K];
  logic signed [AW-1:0]   sum  [K];
  logic signed [AW-1:0]   fin;

  wire step = x_valid && !w_load;

  for (genvar c = 0; c < K; c++) begin : g_cell
    localparam int PREV = (c == 0) ? K-1 : c-1;
    localparam int WIX  = (K - c) % K;

    assign prod[c] = wr[c] * $signed(x_data);
    assign sum[c]  = acc[c] + AW'(prod[c]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wr[c]  <= '0;
        tg[c]  <= (WIX == K-1);
        acc[c] <= '0;
      end else if (w_load) begin
        wr[c]  <= w_flat[WIX*DW +: DW];
        tg[c]  <= (WIX == K-1);
        acc[c] <= '0;
      end else if (step) begin
        wr[c]  <= wr[PREV];
        tg[c]  <= tg[PREV];
        acc[c] <= tg[c] ? '0 : sum[c];
      end
    end
  end

  always_comb begin
    fin = '0;
    for (int c = 0; c < K; c++)
      if (tg[c]) fin = sum[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_valid <= 1'b0;
      y_data  <= '0;
    end else begin
      y_valid <= step;
      if (step) y_data <= fin;
    end
  end

endmodule

// File: rtl/bcast_conv_chk.sv
module bcast_conv_chk #(
  parameter int K  = 3,
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          w_load,
  input logic          x_valid,
  input logic          y_valid,
  input logic [AW-1:0] y_data,
  input logic [K-1:0]  tg
);

  logic [K-1:0] rot;
  if (K == 1) begin : g_one
    assign rot = tg;
  end else begin : g_many
    assign rot = {tg[K-2:0], tg[K-1]};
  end

  assert_one_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tg) == 1);

  assert_out_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && !w_load) |=> y_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_valid && !w_load) |=> !y_valid);

  assert_tag_rotates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && !w_load) |=> tg == $past(rot));

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_valid && !w_load) |=> $stable(tg));

  assert_load_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |=> !y_valid);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !y_valid |-> $stable(y_data));

endmodule

bind bcast_conv bcast_conv_chk #(.K(K), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .w_load(w_load), .x_valid(x_valid),
  .y_valid(y_valid), .y_data(y_data), .tg(tg)
);

// File: tb/bcast_conv_test.sv
module bcast_conv_test;
  localparam int K = 3;
  localparam int DW = 8;
  localparam int AW = 2*DW + $clog2(K+1);
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0, w_load = 0, x_valid = 0;
  logic [K*DW-1:0] w_flat = '0;
  logic [DW-1:0] x_data = '0;
  logic y_valid;
  logic [AW-1:0] y_data;

  int checks = 0, fails = 0;
  int wt [K];
  int hist [K];
  bit done = 0;

  bcast_conv #(.K(K), .DW(DW)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int expect_next(input int x);
    int s = 0;
    for (int j = 0; j < K-1; j++) hist[j] = hist[j+1];
    hist[K-1] = x;
    for (int j = 0; j < K; j++) s += wt[j] * hist[j];
    return s;
  endfunction

  task automatic load(input int w [K], input bit with_sample, input int xs);
    for (int j = 0; j < K; j++) begin
      wt[j] = w[j];
      hist[j] = 0;
      w_flat[j*DW +: DW] = DW'(w[j]);
    end
    w_load = 1; x_valid = with_sample; x_data = DW'(xs);
    @(negedge clk);
    w_load = 0; x_valid = 0;
    check(y_valid == 0, "R6", int'(y_valid), 0);
  endtask

  task automatic send(input int x, input string req);
    int e;
    e = expect_next(x);
    x_valid = 1; x_data = DW'(x);
    @(negedge clk);
    x_valid = 0;
    check(y_valid == 1, req, int'(y_valid), 1);
    check(int'($signed(y_data)) == e, req, int'($signed(y_data)), e);
  endtask

  task automatic idle(input int n);
    logic [AW-1:0] prev;
    prev = y_data;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(y_valid == 0, "R5", int'(y_valid), 0);
      check(y_data == prev, "R8", int'($signed(y_data)), int'($signed(prev)));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(y_valid == 0 && y_data == 0, "R1", int'(y_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(y_valid == 0 && y_data == 0, "R1", int'($signed(y_data)), 0);
  endtask

  task automatic t_impulse;
    int w [K] = '{1, 2, 3};
    load(w, 0, 0);
    send(1, "R4");
    send(0, "R4");
    send(0, "R4");
    send(0, "R4");
  endtask

  task automatic t_random_gaps;
    int w [K];
    for (int j = 0; j < K; j++) w[j] = $signed(DW'($urandom()));
    load(w, 0, 0);
    for (int i = 0; i < 40; i++) begin
      send($signed(DW'($urandom())), "R3");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
  endtask

  task automatic t_reload;
    int w [K];
    for (int i = 0; i < 5; i++) send($signed(DW'($urandom())), "R3");
    for (int j = 0; j < K; j++) w[j] = $signed(DW'($urandom()));
    load(w, 1, 77);
    for (int i = 0; i < 8; i++) send($signed(DW'($urandom())), "R6");
  endtask

  task automatic t_full_scale;
    int w [K];
    for (int j = 0; j < K; j++) w[j] = -(1 << (DW-1));
    load(w, 0, 0);
    for (int i = 0; i < K+2; i++) send(-(1 << (DW-1)), "R7");
  endtask

  initial begin
    void'($urandom(13));
    t_reset();
    t_impulse();
    t_random_gaps();
    t_reload();
    t_full_scale();
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD*100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule